// File: doc/BRIEF.md
# Segmented Page-Table Address Translator

This block turns a 32-bit virtual address into a physical address by way of a page table kept in on-chip registers. Each of two processor cores has its own copy of the table. The virtual space is cut into five fixed windows, and each window owns a contiguous slice of table indices:

| Window | Base | Page size | Access type | Index slice | Target |
|---|---|---|---|---|---|
| Read-only data | 0x3F400000 | 64 KB | data | 0..63 | flash |
| Instruction RAM 0 | 0x40000000 | 64 KB | instruction | 64..127 | flash |
| Instruction RAM 1 | 0x40400000 | 64 KB | instruction | 128..191 | flash |
| Instruction ROM | 0x40800000 | 64 KB | instruction | 192..255 | flash |
| External-RAM data | 0x3F800000 | 32 KB | data | 1152..1279 | external RAM |

Each 64 KB window spans 4 MB. The external-RAM window spans 128 pages of 32 KB. Whether an entry points at flash or at external RAM follows from its index alone.

Software fills the tables through a small register port. One strobe performs a write, an invalidate or a read, addressed by core ID and by table index. The lookup port takes an address, an access type and a core select. One cycle later it returns the physical address, a target tag and a fault flag. Only the populated index slices are stored: 384 entries for each core.

Top module: `mmu_xlat`

## Requirements
- R1: After reset every entry of both tables holds the invalid marker 0x100. The outputs `res_valid`, `res_fault`, `res_ext`, `res_paddr`, `cfg_ack`, `cfg_err` and `cfg_rdata` are all zero. Any lookup faults until an entry is written.
- R2: Inside a window, the entry index equals the slice start plus the page number. The page number is (vaddr − window base) >> 16 for the four 64 KB windows and (vaddr − 0x3F800000) >> 15 for the external-RAM window. The slice starts are 0, 64, 128, 192 and 1152, and the window bases are as listed above.
- R3: A lookup that does not fault returns `res_paddr`:
  - for a flash entry: (entry[7:0] << 16) | vaddr[15:0], with `res_ext` = 0;
  - for an external-RAM entry: (entry[7:0] << 15) | vaddr[14:0], with `res_ext` = 1.
- R4: Access-type rules (`lk_instr` = 1 means instruction):
  - a data access is legal only in the read-only data and external-RAM windows;
  - an instruction access is legal only in the three instruction windows;
  - any other combination faults.
- R5: An address outside all five windows faults. Every faulting result drives `res_paddr` = 0 and `res_ext` = 0.
- R6: An entry whose bit 8 (the invalid marker) is set is unmapped, and a lookup that reaches it faults.
- R7: The two per-core tables are independent. `lk_core` and `cfg_core` pick table 0 or 1. A core value of 2 or 3 makes a lookup fault, and makes a register access return `cfg_err` = 1 without changing either table.
- R8: A register access whose index is outside 0..255 and 1152..1279 returns `cfg_err` = 1, reads zero, and writes nothing.
- R9: A register access returns `cfg_ack` one cycle after `cfg_en`, as follows:
  - a write (`cfg_we`) stores the 9-bit `cfg_wdata`;
  - an invalidate (`cfg_inv`, which wins over `cfg_we`) stores 0x100;
  - a read returns the stored entry on `cfg_rdata`, which is zero for writes and errors.
- R10: `res_valid` rises exactly one cycle after `lk_valid`. In cycles with no result, `res_paddr`, `res_ext` and `res_fault` are zero.
- R11: A lookup issued in the same cycle as a write to the entry it uses sees the value held before the write. The following cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_instr | input | 1 | 1 = instruction access, 0 = data access |
| lk_core | input | 2 | Core select for the lookup |
| lk_vaddr | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_paddr | output | 32 | Translated physical address (zero on fault) |
| res_ext | output | 1 | 1 = external RAM target, 0 = flash |
| res_fault | output | 1 | Translation fault |
| cfg_en | input | 1 | Register access strobe |
| cfg_we | input | 1 | Write the entry |
| cfg_inv | input | 1 | Invalidate the entry |
| cfg_core | input | 2 | Table select for the register access |
| cfg_idx | input | 11 | Table entry index |
| cfg_wdata | input | 9 | Entry value: bit 8 is the invalid marker, bits 7:0 the physical page |
| cfg_ack | output | 1 | Register access acknowledged |
| cfg_err | output | 1 | Register access rejected |
| cfg_rdata | output | 9 | Read data |

## Verification
The bench builds the block with the package defaults: 8-bit physical pages, 64-entry flash slices, a 128-entry external-RAM slice and a 2-bit core field. The 2-bit core field lets the bench drive the illegal core IDs 2 and 3. With slices this small, directed cases reach the first and last entry of every slice and the index gaps on either side. Random traffic then covers the tables densely enough that lookups often land on entries just written, invalidated or shared with a same-cycle write.

// File: rtl/mmu_xlat_pkg.sv
package mmu_xlat_pkg;
    localparam int VA_W        = 32;
    localparam int PA_W        = 32;
    localparam int PPN_W       = 8;
    localparam int ENT_W       = PPN_W + 1;
    localparam int INV_BIT     = PPN_W;
    localparam int FL_SH       = 16;
    localparam int EX_SH       = 15;
    localparam int FL_ENT      = 64;
    localparam int EX_ENT      = 128;
    localparam int FL_REG_N    = 4;
    localparam int FL_PG_W     = $clog2(FL_ENT);
    localparam int EX_PG_W     = $clog2(EX_ENT);
    localparam int IDX_W       = 11;
    localparam int EX_IDX_BASE = 1152;
    localparam int FL_IDX_END  = FL_REG_N * FL_ENT;
    localparam int SLOT_N      = FL_IDX_END + EX_ENT;
    localparam int SLOT_W      = $clog2(SLOT_N);
    localparam int CORE_N      = 2;
    localparam int CORE_W      = 2;

    localparam logic [VA_W-1:0] FL_WIN    = VA_W'(FL_ENT) << FL_SH;
    localparam logic [VA_W-1:0] EX_WIN    = VA_W'(EX_ENT) << EX_SH;
    localparam logic [VA_W-1:0] DROM_BASE = 32'h3F40_0000;
    localparam logic [VA_W-1:0] XRAM_BASE = 32'h3F80_0000;
    localparam logic [VA_W-1:0] IWIN_BASE = 32'h4000_0000;
    localparam logic [PA_W-1:0] FL_OFF_M  = (PA_W'(1) << FL_SH) - PA_W'(1);
    localparam logic [PA_W-1:0] EX_OFF_M  = (PA_W'(1) << EX_SH) - PA_W'(1);
    localparam logic [ENT_W-1:0] INV_ENT  = ENT_W'(1) << INV_BIT;

    // Flash window k: 0 is read-only data, 1..3 the instruction windows
    function automatic logic [VA_W-1:0] fl_base(input int k);
        return (k == 0) ? DROM_BASE : IWIN_BASE + VA_W'(k - 1) * FL_WIN;
    endfunction

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] slot;
    } slot_sel_t;

    // Architectural index -> dense storage slot
    function automatic slot_sel_t idx_to_slot(input logic [IDX_W-1:0] idx);
        slot_sel_t r;
        r = '0;
        if (idx < IDX_W'(FL_IDX_END)) begin
            r.ok   = 1'b1;
            r.slot = SLOT_W'(idx);
        end else if (idx >= IDX_W'(EX_IDX_BASE) && idx < IDX_W'(EX_IDX_BASE + EX_ENT)) begin
            r.ok   = 1'b1;
            r.slot = SLOT_W'(idx - IDX_W'(EX_IDX_BASE)) + SLOT_W'(FL_IDX_END);
        end
        return r;
    endfunction

    typedef struct packed {
        logic             res_valid;
        logic [PA_W-1:0]  res_paddr;
        logic             res_ext;
        logic             res_fault;
        logic             cfg_ack;
        logic             cfg_err;
        logic [ENT_W-1:0] cfg_rdata;
    } xlat_st_t;
endpackage

// File: rtl/mmu_region_dec.sv
module mmu_region_dec
    import mmu_xlat_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr,
    output logic              hit,
    output logic              data_win,
    output logic              ext,
    output logic [SLOT_W-1:0] slot
);
    logic [FL_REG_N-1:0] fl_hit;
    logic [SLOT_W-1:0]   fl_slot [FL_REG_N];

    for (genvar k = 0; k < FL_REG_N; k++) begin : g_fl
        localparam logic [VA_W-1:0] BASE = fl_base(k);
        logic [VA_W-1:0] rel;
        assign rel        = vaddr - BASE;
        assign fl_hit[k]  = (vaddr >= BASE) && (rel < FL_WIN);
        assign fl_slot[k] = SLOT_W'(k * FL_ENT) + SLOT_W'(rel[FL_SH +: FL_PG_W]);
    end

    logic [VA_W-1:0]   x_rel;
    logic              x_hit;
    logic [SLOT_W-1:0] x_slot;
    assign x_rel  = vaddr - XRAM_BASE;
    assign x_hit  = (vaddr >= XRAM_BASE) && (x_rel < EX_WIN);
    assign x_slot = SLOT_W'(FL_IDX_END) + SLOT_W'(x_rel[EX_SH +: EX_PG_W]);

    always_comb begin
        hit      = 1'b0;
        data_win = 1'b0;
        ext      = 1'b0;
        slot     = '0;
        if (x_hit) begin
            hit      = 1'b1;
            data_win = 1'b1;
            ext      = 1'b1;
            slot     = x_slot;
        end
        for (int k = 0; k < FL_REG_N; k++) begin
            if (fl_hit[k]) begin
                hit      = 1'b1;
                data_win = (k == 0);
                slot     = fl_slot[k];
            end
        end
    end
endmodule

// File: rtl/mmu_tbl_bank.sv
module mmu_tbl_bank
    import mmu_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ENT_W-1:0]  wr_val,
    input  logic [SLOT_W-1:0] rd_a_slot,
    output logic [ENT_W-1:0]  rd_a_val,
    input  logic [SLOT_W-1:0] rd_b_slot,
    output logic [ENT_W-1:0]  rd_b_val
);
    logic [ENT_W-1:0] tbl_d [SLOT_N];
    logic [ENT_W-1:0] tbl_q [SLOT_N];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) tbl_d[wr_slot] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '{default: INV_ENT};
        else        tbl_q <= tbl_d;
    end

    assign rd_a_val = tbl_q[rd_a_slot];
    assign rd_b_val = tbl_q[rd_b_slot];
endmodule

// File: rtl/mmu_xlat.sv
module mmu_xlat
    import mmu_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_instr,
    input  logic [CORE_W-1:0] lk_core,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              res_valid,
    output logic [PA_W-1:0]   res_paddr,
    output logic              res_ext,
    output logic              res_fault,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic              cfg_inv,
    input  logic [CORE_W-1:0] cfg_core,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ENT_W-1:0]  cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_err,
    output logic [ENT_W-1:0]  cfg_rdata
);
    xlat_st_t st_d, st_q;

    logic              dec_hit, dec_data, dec_ext;
    logic [SLOT_W-1:0] dec_slot;
    slot_sel_t         cfg_sel;
    logic              cfg_core_ok, lk_core_ok, cfg_mod;
    logic [ENT_W-1:0]  lk_ent [CORE_N];
    logic [ENT_W-1:0]  rd_ent [CORE_N];
    logic [ENT_W-1:0]  lk_e, rd_e;

    mmu_region_dec u_dec (
        .vaddr    (lk_vaddr),
        .hit      (dec_hit),
        .data_win (dec_data),
        .ext      (dec_ext),
        .slot     (dec_slot)
    );

    assign cfg_sel     = idx_to_slot(cfg_idx);
    assign cfg_core_ok = cfg_core < CORE_W'(CORE_N);
    assign lk_core_ok  = lk_core < CORE_W'(CORE_N);
    assign cfg_mod     = cfg_en && cfg_core_ok && cfg_sel.ok && (cfg_we || cfg_inv);

    for (genvar g = 0; g < CORE_N; g++) begin : g_core
        mmu_tbl_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_mod && (cfg_core == CORE_W'(g))),
            .wr_slot   (cfg_sel.slot),
            .wr_val    (cfg_inv ? INV_ENT : cfg_wdata),
            .rd_a_slot (dec_slot),
            .rd_a_val  (lk_ent[g]),
            .rd_b_slot (cfg_sel.slot),
            .rd_b_val  (rd_ent[g])
        );
    end

    always_comb begin
        lk_e = INV_ENT;
        rd_e = '0;
        for (int g = 0; g < CORE_N; g++) begin
            if (lk_core == CORE_W'(g))  lk_e = lk_ent[g];
            if (cfg_core == CORE_W'(g)) rd_e = rd_ent[g];
        end
    end

    always_comb begin
        st_d = '0;
        if (lk_valid) begin
            st_d.res_valid = 1'b1;
            st_d.res_fault = !dec_hit || (dec_data == lk_instr) || !lk_core_ok || lk_e[INV_BIT];
            if (!st_d.res_fault) begin
                st_d.res_ext = dec_ext;
                if (dec_ext)
                    st_d.res_paddr = (PA_W'(lk_e[PPN_W-1:0]) << EX_SH) | (lk_vaddr & EX_OFF_M);
                else
                    st_d.res_paddr = (PA_W'(lk_e[PPN_W-1:0]) << FL_SH) | (lk_vaddr & FL_OFF_M);
            end
        end
        if (cfg_en) begin
            st_d.cfg_ack = 1'b1;
            st_d.cfg_err = !cfg_core_ok || !cfg_sel.ok;
            if (!st_d.cfg_err && !cfg_we && !cfg_inv) st_d.cfg_rdata = rd_e;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.res_valid;
    assign res_paddr = st_q.res_paddr;
    assign res_ext   = st_q.res_ext;
    assign res_fault = st_q.res_fault;
    assign cfg_ack   = st_q.cfg_ack;
    assign cfg_err   = st_q.cfg_err;
    assign cfg_rdata = st_q.cfg_rdata;
endmodule

// File: rtl/mmu_xlat_chk.sv
module mmu_xlat_chk
    import mmu_xlat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_instr,
    input logic [CORE_W-1:0] lk_core,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              res_valid,
    input logic [PA_W-1:0]   res_paddr,
    input logic              res_ext,
    input logic              res_fault,
    input logic              cfg_en,
    input logic              cfg_we,
    input logic              cfg_inv,
    input logic [CORE_W-1:0] cfg_core,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [ENT_W-1:0]  cfg_wdata,
    input logic              cfg_ack,
    input logic              cfg_err,
    input logic [ENT_W-1:0]  cfg_rdata
);
    localparam logic [VA_W-1:0] DATA_END = XRAM_BASE + EX_WIN;
    localparam logic [VA_W-1:0] INST_END = IWIN_BASE + VA_W'(FL_REG_N - 1) * FL_WIN;

    logic in_data, in_inst;
    assign in_data = (lk_vaddr >= DROM_BASE) && (lk_vaddr < DATA_END);
    assign in_inst = (lk_vaddr >= IWIN_BASE) && (lk_vaddr < INST_END);

    AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> res_valid); // R10
    AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !res_valid); // R10
    AST_IDLE_RES_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> (res_paddr == '0) && !res_fault && !res_ext); // R10
    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) res_fault |-> (res_paddr == '0) && !res_ext); // R5
    AST_OUTSIDE_FAULT: assert property (@(posedge clk) disable iff (!rst_n) lk_valid && !in_data && !in_inst |=> res_fault); // R5
    AST_INSTR_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) lk_valid && lk_instr && in_data |=> res_fault); // R4
    AST_DATA_IN_INSTR: assert property (@(posedge clk) disable iff (!rst_n) lk_valid && !lk_instr && in_inst |=> res_fault); // R4
    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> res_fault || (res_paddr[EX_SH-1:0] == $past(lk_vaddr[EX_SH-1:0]))); // R3
    AST_BAD_CORE_LK: assert property (@(posedge clk) disable iff (!rst_n) lk_valid && (lk_core >= CORE_W'(CORE_N)) |=> res_fault); // R7
    AST_BAD_CORE_CFG: assert property (@(posedge clk) disable iff (!rst_n) cfg_en && (cfg_core >= CORE_W'(CORE_N)) |=> cfg_err); // R7
    AST_IDX_GAP_ERR: assert property (@(posedge clk) disable iff (!rst_n) cfg_en && (cfg_idx >= IDX_W'(FL_IDX_END)) && (cfg_idx < IDX_W'(EX_IDX_BASE)) |=> cfg_err && (cfg_rdata == '0)); // R8
    AST_CFG_ACK: assert property (@(posedge clk) disable iff (!rst_n) cfg_en |=> cfg_ack); // R9
    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n) !cfg_en |=> !cfg_ack && !cfg_err); // R9
    AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n) cfg_en && (cfg_we || cfg_inv) |=> (cfg_rdata == '0)); // R9
endmodule

bind mmu_xlat mmu_xlat_chk u_chk (.*);

// File: tb/tb_mmu_xlat.sv
module tb_mmu_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_instr = 0;
    logic [1:0]  lk_core = 0;
    logic [31:0] lk_vaddr = 0;
    logic        res_valid, res_ext, res_fault;
    logic [31:0] res_paddr;
    logic        cfg_en = 0, cfg_we = 0, cfg_inv = 0;
    logic [1:0]  cfg_core = 0;
    logic [10:0] cfg_idx = 0;
    logic [8:0]  cfg_wdata = 0;
    logic        cfg_ack, cfg_err;
    logic [8:0]  cfg_rdata;

    always #2 clk = ~clk;

    mmu_xlat dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_instr(lk_instr), .lk_core(lk_core), .lk_vaddr(lk_vaddr),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_ext(res_ext), .res_fault(res_fault),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_inv(cfg_inv), .cfg_core(cfg_core),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rdata(cfg_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [8:0] mdl [0:1][0:1279];

    function automatic bit idx_legal(input int idx);
        return (idx >= 0 && idx < 256) || (idx >= 1152 && idx < 1280);
    endfunction

    // Behavioural translation model
    task automatic ref_lookup(input logic [31:0] va, input bit instr, input int core,
                              output logic [31:0] pa, output bit ext, output bit flt);
        int idx, sh;
        bit dwin;
        idx = -1; sh = 16; dwin = 0; ext = 0; pa = 0;
        if (va >= 32'h3F40_0000 && va < 32'h3F80_0000) begin
            idx = int'((va - 32'h3F40_0000) / 32'h1_0000); dwin = 1;
        end else if (va >= 32'h3F80_0000 && va < 32'h3FC0_0000) begin
            idx = 1152 + int'((va - 32'h3F80_0000) / 32'h8000); dwin = 1; sh = 15;
        end else if (va >= 32'h4000_0000 && va < 32'h40C0_0000) begin
            idx = 64 + int'((va - 32'h4000_0000) / 32'h1_0000);
        end
        flt = (idx < 0) || (dwin == instr) || (core > 1);
        if (!flt) flt = mdl[core][idx][8];
        if (!flt) begin
            ext = (sh == 15);
            pa = ({24'd0, mdl[core][idx][7:0]} << sh) | (va & ((32'd1 << sh) - 1));
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_instr = 0; lk_core = 0; lk_vaddr = 0;
        cfg_en = 0; cfg_we = 0; cfg_inv = 0; cfg_core = 0; cfg_idx = 0; cfg_wdata = 0;
    endtask

    // Apply current inputs for one clock and compare the registered response
    task automatic tick(input string tag);
        logic [31:0] e_pa;
        bit e_ext, e_flt, e_err;
        logic [8:0] e_rd;
        e_pa = 0; e_ext = 0; e_flt = 0; e_err = 0; e_rd = 0;
        if (lk_valid) ref_lookup(lk_vaddr, lk_instr, int'(lk_core), e_pa, e_ext, e_flt);
        if (cfg_en) begin
            e_err = (cfg_core > 1) || !idx_legal(int'(cfg_idx));
            if (!e_err && !cfg_we && !cfg_inv) e_rd = mdl[cfg_core][cfg_idx];
            if (!e_err && (cfg_we || cfg_inv)) mdl[cfg_core][cfg_idx] = cfg_inv ? 9'h100 : cfg_wdata;
        end
        @(negedge clk);
        n_chk++;
        if (res_valid !== lk_valid || res_paddr !== e_pa || res_ext !== e_ext || res_fault !== e_flt ||
            cfg_ack !== cfg_en || cfg_err !== e_err || cfg_rdata !== e_rd) begin
            n_fail++;
            $display("FAIL %s: got v=%0b pa=%h ext=%0b flt=%0b ack=%0b err=%0b rd=%h exp v=%0b pa=%h ext=%0b flt=%0b ack=%0b err=%0b rd=%h",
                     tag, res_valid, res_paddr, res_ext, res_fault, cfg_ack, cfg_err, cfg_rdata,
                     lk_valid, e_pa, e_ext, e_flt, cfg_en, e_err, e_rd);
        end
        idle_inputs();
    endtask

    task automatic lk(input logic [31:0] va, input bit instr, input logic [1:0] core, input string tag);
        lk_valid = 1; lk_vaddr = va; lk_instr = instr; lk_core = core;
        tick(tag);
    endtask

    task automatic cfg(input bit we, input bit inv, input logic [1:0] core, input int idx,
                       input logic [8:0] wd, input string tag);
        cfg_en = 1; cfg_we = we; cfg_inv = inv; cfg_core = core; cfg_idx = 11'(idx); cfg_wdata = wd;
        tick(tag);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 1280; i++) mdl[c][i] = 9'h100;
        idle_inputs();
        repeat (3) @(negedge clk);
        tick("R1 outputs during reset");
        rst_n = 1'b1;
        tick("R1 idle after reset");
        lk(32'h3F40_1234, 0, 0, "R1 lookup faults after reset");
        cfg(0, 0, 1, 5, 0, "R1 reset entry reads invalid marker");
        cfg(0, 0, 0, 1279, 0, "R1 last ext entry reads invalid marker");

        // R2 R3: flash windows
        cfg(1, 0, 0, 3, 9'h012, "R9 write drom entry");
        lk(32'h3F43_1234, 0, 0, "R2 R3 drom translate");
        cfg(1, 0, 0, 0, 9'h0A5, "R9 write drom first");
        lk(32'h3F40_FFFF, 0, 0, "R2 drom first page top offset");
        cfg(1, 0, 0, 66, 9'h021, "R9 write iram0");
        lk(32'h4002_ABCD, 1, 0, "R2 R3 iram0 translate");
        cfg(1, 0, 0, 129, 9'h0C3, "R9 write iram1");
        lk(32'h4041_0042, 1, 0, "R2 iram1 translate");
        cfg(1, 0, 0, 255, 9'h0FF, "R9 write irom last");
        lk(32'h40BF_8001, 1, 0, "R2 irom last page");
        // R2 R3: external RAM window
        cfg(1, 0, 0, 1157, 9'h033, "R9 write ext entry");
        lk(32'h3F82_FABC, 0, 0, "R2 R3 ext translate");
        cfg(1, 0, 0, 1279, 9'h07E, "R9 write ext last");
        lk(32'h3FBF_FFFF, 0, 0, "R2 R3 ext last page");
        cfg(0, 0, 0, 1157, 0, "R9 readback ext entry");

        // R4 access type
        lk(32'h3F43_0000, 1, 0, "R4 instr in drom");
        lk(32'h3F82_8000, 1, 0, "R4 instr in ext");
        lk(32'h4002_0000, 0, 0, "R4 data in iram0");
        lk(32'h40BF_0000, 0, 0, "R4 data in irom");

        // R5 outside
        lk(32'h3F3F_FFFF, 0, 0, "R5 below drom");
        lk(32'h3FC0_0000, 0, 0, "R5 above ext");
        lk(32'h40C0_0000, 1, 0, "R5 above irom");
        lk(32'h0000_0000, 0, 0, "R5 address zero");

        // R6 invalid marker
        cfg(0, 1, 0, 3, 9'h077, "R9 invalidate wins over data");
        cfg(0, 0, 0, 3, 0, "R9 read invalidated");
        lk(32'h3F43_0000, 0, 0, "R6 invalidated entry faults");
        cfg(1, 1, 0, 66, 9'h021, "R9 invalidate wins over write");
        lk(32'h4002_0000, 1, 0, "R6 entry with marker faults");
        cfg(1, 0, 0, 66, 9'h121, "R6 write value with marker");
        lk(32'h4002_0000, 1, 0, "R6 marker bit in written value");

        // R7 cores
        cfg(1, 0, 1, 66, 9'h044, "R7 write core1");
        cfg(1, 0, 0, 66, 9'h021, "R7 write core0");
        lk(32'h4002_0010, 1, 1, "R7 core1 table");
        lk(32'h4002_0010, 1, 0, "R7 core0 table");
        cfg(1, 0, 2, 66, 9'h099, "R7 write illegal core rejected");
        cfg(0, 0, 3, 66, 0, "R7 read illegal core rejected");
        lk(32'h4002_0010, 1, 2, "R7 lookup illegal core");
        lk(32'h4002_0010, 1, 1, "R7 core1 unchanged after reject");

        // R8 index gaps
        cfg(1, 0, 0, 256, 9'h011, "R8 index 256");
        cfg(0, 0, 0, 1151, 0, "R8 index 1151");
        cfg(1, 0, 1, 1280, 9'h011, "R8 index 1280");
        cfg(0, 0, 0, 2047, 0, "R8 index 2047");
        cfg(0, 0, 0, 255, 0, "R8 neighbour 255 intact");

        // R11 same-cycle write and lookup
        cfg_en = 1; cfg_we = 1; cfg_core = 0; cfg_idx = 11'd0; cfg_wdata = 9'h055;
        lk_valid = 1; lk_vaddr = 32'h3F40_0100; lk_instr = 0; lk_core = 0;
        tick("R11 lookup sees old value");
        lk(32'h3F40_0100, 0, 0, "R11 next lookup sees new value");
        cfg_en = 1; cfg_inv = 1; cfg_core = 0; cfg_idx = 11'd1279;
        lk_valid = 1; lk_vaddr = 32'h3FBF_8000; lk_instr = 0; lk_core = 0;
        tick("R11 invalidate same cycle");
        lk(32'h3FBF_8000, 0, 0, "R11 after invalidate");

        // R10 gaps between requests
        tick("R10 idle cycle");

        // Random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 5));
            if ($urandom_range(0, 1) == 1) begin
                lk_valid = 1;
                lk_instr = 1'($urandom_range(0, 1));
                lk_core = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
                case (r)
                    0: lk_vaddr = 32'h3F40_0000 + ($urandom % 32'h40_0000);
                    1: lk_vaddr = 32'h3F80_0000 + ($urandom % 32'h40_0000);
                    2, 3: lk_vaddr = 32'h4000_0000 + ($urandom % 32'hC0_0000);
                    4: lk_vaddr = 32'h3F40_0000 + ($urandom % 32'h180_0000);
                    default: lk_vaddr = $urandom;
                endcase
                if (r < 4) lk_instr = (r >= 2);
            end
            if ($urandom_range(0, 2) != 0) begin
                cfg_en = 1;
                cfg_core = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
                case ($urandom_range(0, 5))
                    0: cfg_idx = 11'($urandom);
                    1, 2: cfg_idx = 11'(1152 + $urandom_range(0, 127));
                    default: cfg_idx = 11'($urandom_range(0, 255));
                endcase
                r = int'($urandom_range(0, 7));
                cfg_we = (r < 5);
                cfg_inv = (r == 5);
                cfg_wdata = ($urandom_range(0, 7) == 0) ? 9'($urandom) : {1'b0, 8'($urandom)};
            end
            tick("R2 R3 R4 R6 R7 R9 R11 random traffic");
        end

        report();
    end
endmodule